// File: doc/BRIEF.md
# Reset Cause Status Register

This block records which reset source or sources produced the most recent reset. Software reads the record as one 8-bit read-only status byte on a simple CPU bus. Each source arrives as a one-cycle request, or as a level, on its own input:

- power-on
- external reset pin
- watchdog timeout
- illegal opcode
- illegal fetch address
- monitor-mode entry
- low supply voltage

A power-on request clears the record and leaves only its own flag. Every other source adds its own flag to the flags already held. The flags survive the rest of the reset sequence. They clear as a side effect of software reading the byte.

A read returns the flags as they stood before the clear. The clear takes effect on the clock edge that ends the read cycle. A request that arrives in the same cycle as a clearing read is kept. A power-on request that coincides with other requests keeps those flags too, so a slow supply ramp can show both the power-on flag and the low-voltage flag.

The bus has one fixed register address, set by a parameter. A read strobe at that address returns the byte combinationally in the same cycle. Any strobe with the write line high changes nothing and returns zero.

Top module: `rst_cause_reg`

## Requirements
- R1: The read byte layout is bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal fetch address, bit 2 monitor-mode entry, bit 1 low voltage; bit 0 always reads 0.
- R2: A power-on request sets bit 7 and clears every flag whose source is not also requesting in that cycle.
- R3: A request from any non-power-on source sets only its own flag and leaves all other flags unchanged.
- R4: Several flags may be held at once, including power-on together with another source requested in the same cycle.
- R5: A read at the register address returns the flags held before the read; all flags are clear on the next cycle unless a request arrives.
- R6: A request in the same cycle as a clearing read sets its flag, and that flag stays set after the read.
- R7: A write strobe (bus_sel_wr high, with or without bus_sel_rd) changes no flag and returns 0 on bus_rdata.
- R8: A read at any other address neither returns the flags nor clears them; bus_rdata is 0 whenever no read hits the register.
- R9: After a power-on request alone, the register reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on reset request |
| pin_req | input | 1 | External reset pin request |
| wdog_req | input | 1 | Watchdog timeout request |
| bad_op_req | input | 1 | Illegal opcode request |
| bad_fetch_req | input | 1 | Opcode fetch from unimplemented address |
| mon_req | input | 1 | Monitor-mode entry reset request |
| lowv_req | input | 1 | Low supply voltage request |
| bus_sel_rd | input | 1 | Bus read strobe |
| bus_sel_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus address |
| bus_rdata | output | 8 | Read data, 0 unless a read hits |

## Verification
Each source is requested alone, so the tests can tell whether a request lands on the wrong bit position. Sources are then stacked over several cycles, which shows whether a non-power-on request wipes flags set earlier. A power-on request is applied on top of a full set of flags, and then together with the low-voltage request; this separates "power-on clears the others" from "power-on ignores requests in the same cycle". Last come reads that coincide with a request, with a write strobe, or with a wrong address. These show whether the read data is taken before the clear, and whether the clear is gated only by a true read hit.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned NUM_SRC  = 7;
  localparam int unsigned DATA_W   = NUM_SRC + 1;
  // index of each flag within the stored vector (read bit = index + 1)
  localparam int unsigned IDX_POR   = 6;
  localparam int unsigned IDX_PIN   = 5;
  localparam int unsigned IDX_WDOG  = 4;
  localparam int unsigned IDX_OP    = 3;
  localparam int unsigned IDX_FETCH = 2;
  localparam int unsigned IDX_MON   = 1;
  localparam int unsigned IDX_LOWV  = 0;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rcs_bus_decode.sv
module rcs_bus_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_hit
);
  // a strobe carrying the write line is a write and never a read
  always_comb rd_hit = rd && !wr && (addr == REG_ADDR);
endmodule

// File: rtl/rcs_flag_cell.sv
module rcs_flag_cell (
  input  logic clk,
  input  logic req,
  input  logic wipe,
  input  logic clr,
  output logic q
);
  // a new request always wins; otherwise hold unless wiped or read-cleared
  always_ff @(posedge clk) begin
    q <= req | (q & ~clr & ~wipe);
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0040
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              pin_req,
  input  logic              wdog_req,
  input  logic              bad_op_req,
  input  logic              bad_fetch_req,
  input  logic              mon_req,
  input  logic              lowv_req,
  input  logic              bus_sel_rd,
  input  logic              bus_sel_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_rdata
);
  import rcs_pkg::*;

  src_vec_t req_vec;
  src_vec_t q_flags;
  logic     rd_hit;

  always_comb begin
    req_vec            = '0;
    req_vec[IDX_POR]   = por_req;
    req_vec[IDX_PIN]   = pin_req;
    req_vec[IDX_WDOG]  = wdog_req;
    req_vec[IDX_OP]    = bad_op_req;
    req_vec[IDX_FETCH] = bad_fetch_req;
    req_vec[IDX_MON]   = mon_req;
    req_vec[IDX_LOWV]  = lowv_req;
  end

  rcs_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .rd     (bus_sel_rd),
    .wr     (bus_sel_wr),
    .addr   (bus_addr),
    .rd_hit (rd_hit)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    rcs_flag_cell u_cell (
      .clk  (clk),
      .req  (req_vec[i]),
      .wipe (por_req),
      .clr  (rd_hit),
      .q    (q_flags[i])
    );
  end

  always_comb bus_rdata = rd_hit ? {q_flags, 1'b0} : 8'h00;
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0040
) (
  input logic              clk,
  input logic              por_req,
  input logic              pin_req,
  input logic              wdog_req,
  input logic              bad_op_req,
  input logic              bad_fetch_req,
  input logic              mon_req,
  input logic              lowv_req,
  input logic              bus_sel_rd,
  input logic              bus_sel_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic [6:0]        q_flags
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (por_req) armed <= 1'b1;

  logic hit, any_req, other_req;
  always_comb begin
    hit       = bus_sel_rd && !bus_sel_wr && (bus_addr == REG_ADDR);
    other_req = pin_req | wdog_req | bad_op_req | bad_fetch_req | mon_req | lowv_req;
    any_req   = por_req | other_req;
  end

  // R2
  por_sets_chk: assert property (@(posedge clk) disable iff (!armed)
    por_req |=> q_flags[6]);
  // R2
  por_wipes_chk: assert property (@(posedge clk) disable iff (!armed)
    (por_req && !other_req) |=> (q_flags[5:0] == 6'b0));
  // R3
  pin_sets_chk: assert property (@(posedge clk) disable iff (!armed)
    pin_req |=> q_flags[5]);
  // R3
  keep_flags_chk: assert property (@(posedge clk) disable iff (!armed)
    (!por_req && !hit) |=> ((q_flags & $past(q_flags)) == $past(q_flags)));
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!armed)
    (hit && !any_req) |=> (q_flags == 7'b0));
  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!armed)
    (!hit && !any_req) |=> $stable(q_flags));
  // R8
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!armed)
    !hit |-> (bus_rdata == 8'h00));
  // R1
  always_comb if (armed) bit0_zero_chk: assert (bus_rdata[0] == 1'b0);
endmodule

bind rst_cause_reg rst_cause_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .por_req(por_req), .pin_req(pin_req), .wdog_req(wdog_req),
  .bad_op_req(bad_op_req), .bad_fetch_req(bad_fetch_req), .mon_req(mon_req),
  .lowv_req(lowv_req), .bus_sel_rd(bus_sel_rd), .bus_sel_wr(bus_sel_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .q_flags(q_flags)
);

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] RA = 16'h0040;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [6:0]    req;  // {por,pin,wdog,op,fetch,mon,lowv}
  logic          rd, wr;
  logic [AW-1:0] addr;
  logic [7:0]    rdata;
  int total = 0, bad = 0;

  rst_cause_reg #(.ADDR_W(AW), .REG_ADDR(RA)) u_rst_cause_reg (
    .clk(clk), .por_req(req[6]), .pin_req(req[5]), .wdog_req(req[4]),
    .bad_op_req(req[3]), .bad_fetch_req(req[2]), .mon_req(req[1]),
    .lowv_req(req[0]), .bus_sel_rd(rd), .bus_sel_wr(wr), .bus_addr(addr),
    .bus_rdata(rdata)
  );

  task automatic check(input logic [7:0] exp, input string tag);
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, rdata, exp);
    end
  endtask

  // one cycle with given requests and bus controls, check data mid-cycle
  task automatic cyc(input logic [6:0] r, input logic rd_i, input logic wr_i,
                     input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    req = r; rd = rd_i; wr = wr_i; addr = a;
    #1 check(exp, tag);
    @(negedge clk);
    req = '0; rd = 1'b0; wr = 1'b0; addr = '0;
  endtask

  task automatic pulse(input logic [6:0] r);
    @(negedge clk); req = r;
    @(negedge clk); req = '0;
  endtask

  task automatic rd_at(input logic [7:0] exp, input string tag);
    cyc(7'b0, 1'b1, 1'b0, RA, exp, tag);
  endtask

  task automatic t_power_on();
    pulse(7'b1000000);
    rd_at(8'h80, "R9 power-on value");
    rd_at(8'h00, "R5 cleared after read");
  endtask

  task automatic t_single_sources();
    for (int i = 0; i < 6; i++) begin
      pulse(7'(1 << i));
      rd_at(8'(2 << i), "R1 R3 single source bit");
    end
  endtask

  task automatic t_accumulate();
    pulse(7'b0010000);
    pulse(7'b0001000);
    pulse(7'b0000001);
    rd_at(8'h32, "R3 R4 stacked sources");
  endtask

  task automatic t_por_wipes();
    pulse(7'b0111111);
    pulse(7'b1000000);
    rd_at(8'h80, "R2 power-on wipes others");
    pulse(7'b0100000);
    pulse(7'b1000001);
    rd_at(8'h82, "R2 R4 power-on with low voltage");
  endtask

  task automatic t_read_collide();
    pulse(7'b0000100);
    cyc(7'b0010000, 1'b1, 1'b0, RA, 8'h08, "R5 read returns pre-clear");
    rd_at(8'h20, "R6 same-cycle request survives");
  endtask

  task automatic t_write_ignored();
    pulse(7'b0000010);
    cyc(7'b0, 1'b0, 1'b1, RA, 8'h00, "R7 write returns zero");
    cyc(7'b0, 1'b1, 1'b1, RA, 8'h00, "R7 read+write is write");
    rd_at(8'h04, "R7 flags kept after write");
  endtask

  task automatic t_wrong_addr();
    pulse(7'b0000001);
    cyc(7'b0, 1'b1, 1'b0, RA + 1, 8'h00, "R8 other address returns zero");
    cyc(7'b0, 1'b0, 1'b0, RA, 8'h00, "R8 no strobe returns zero");
    rd_at(8'h02, "R8 flags kept after miss");
  endtask

  initial begin
    req = '0; rd = 1'b0; wr = 1'b0; addr = '0;
    t_power_on();
    t_single_sources();
    t_accumulate();
    t_por_wipes();
    t_read_collide();
    t_write_ignored();
    t_wrong_addr();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule